// File: doc/BRIEF.md
# Page-Mode ROM Read Sequencer

This block turns CPU-side burst read requests into read cycles on an asynchronous ROM with a 32-bit data bus, for one chip-select region. A request gives a byte address, a word count and a flag saying whether the target is the page-capable region. The sequencer drives the memory address, chip select and read strobe. It samples the ROM data bus on the final cycle of each access and returns every word with a single-cycle valid pulse.

When page operation is enabled and the request targets the page-capable region, the first word of a burst is read with a full normal access of `n` cycles. Each later word in the same ROM page is read with a short page access of 1 to 4 cycles, and chip select stays asserted throughout. When the next word address moves into a new page, the strobes drop for one cycle. The first word of the new page then gets a full normal access, and page timing resumes after it. With page operation disabled, or for the other region, every word is a separate normal access.

The configuration is sampled when a request is accepted. Page size, page-access rate, the page-mode flag and the normal access length stay fixed for the whole burst.

Top module: `pgrom_seq`

## Requirements
- R1: After reset and whenever no burst is in progress, `req_ready` is 1 and `mem_cs`, `mem_rd` and `rd_valid` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and the first access starts in the next cycle. The two low address bits are forced to 0. A `req_len` of 0 is treated as one word.
- R3: The first access of a burst, and every access that follows an idle gap, lasts n cycles. Here n is the larger of `cfg_wait` and the page cycle count plus one.
- R4: `cfg_page_cyc` gives the length of each in-page access after the first: code 0 gives 1 cycle, 1 gives 2, 2 gives 3 and 3 gives 4.
- R5: `cfg_page_size` selects the page in bytes: code 0 gives 64, 1 gives 32, 2 gives 16 and 3 gives 8. Two word addresses lie in the same page when their bits at and above position 6, 5, 4 or 3 (for codes 0 to 3) are equal.
- R6: Each later word of a burst uses the byte address of the previous word plus 4.
- R7: When the next word lies in a different page, `mem_cs` and `mem_rd` go low for exactly one cycle. That word then takes a full n-cycle access, and the word after it goes back to page timing.
- R8: When `cfg_page_en` is 0 or `req_page_region` is 0 at acceptance, every word takes an n-cycle access, with one idle cycle between words.
- R9: Between consecutive accesses in the same page, `mem_cs` and `mem_rd` stay at 1 while only `mem_addr` changes.
- R10: `mem_data` is sampled on the last cycle of each access and appears on `rd_data` with `rd_valid` high for the single following cycle.
- R11: After the last word of a burst, `mem_cs` and `mem_rd` are 0 for one cycle while `req_ready` is still 0. `req_ready` returns to 1 in the cycle after that.
- R12: Changes to the configuration inputs while a burst is running do not affect that burst's timing or addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Start byte address of the burst |
| req_len | input | LEN_W | Number of words (0 means 1) |
| req_page_region | input | 1 | Request targets the page-capable region |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| rd_valid | output | 1 | One-cycle pulse marking a returned word |
| rd_data | output | 32 | Returned word |
| cfg_page_en | input | 1 | Page operation enable |
| cfg_page_cyc | input | 2 | Page-access cycle code |
| cfg_page_size | input | 2 | Page-size code |
| cfg_wait | input | WAIT_W | Normal access length n in cycles |
| mem_addr | output | ADDR_W | ROM byte address |
| mem_cs | output | 1 | ROM chip select, active high |
| mem_rd | output | 1 | ROM read strobe, active high |
| mem_data | input | 32 | ROM data bus |

## Verification
The hardest case to reach is a page crossing that happens in the middle of a burst, with an access that was clamped to its minimum length. This needs an unaligned start offset, the smallest page size, a low wait setting and a slow page rate all in the same request. Directed bursts place the start address a few words before each of the four page boundaries. A seeded sweep then mixes offsets, lengths and all configuration codes. One burst changes every configuration input right after acceptance, so any timing that follows the live inputs shows up against the model.

// File: rtl/pgrom_pkg.sv
package pgrom_pkg;

    localparam int unsigned BUS_BYTES = 4;
    localparam logic [1:0]  SIZE_CODE_RST = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       page_on;
        logic [1:0] cyc_code;
        logic [1:0] size_code;
    } pg_cfg_t;

    // Cycles for one in-page access: code + 1.
    function automatic logic [2:0] page_cycles(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

    // Lowest address bit that names the page: 6 for 64 bytes down to 3 for 8.
    function automatic logic [2:0] page_shift(input logic [1:0] code);
        return 3'd6 - {1'b0, code};
    endfunction

endpackage

// File: rtl/pgrom_pagechk.sv
module pgrom_pagechk
    import pgrom_pkg::*;
#(
    parameter int unsigned AW = 24
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [1:0]    size_code,
    output logic [AW-1:0] next_addr,
    output logic          same_page
);
    logic [2:0] shift;

    assign next_addr = cur_addr + AW'(BUS_BYTES);
    assign shift     = page_shift(size_code);

    always_comb begin
        same_page = 1'b1;
        for (int i = 0; i < AW; i++) begin
            if ((i >= int'(shift)) && (cur_addr[i] != next_addr[i])) begin
                same_page = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgrom_cycle.sv
module pgrom_cycle #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/pgrom_seq.sv
module pgrom_seq
    import pgrom_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned LEN_W  = 6,
    parameter int unsigned WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_page_region,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              cfg_page_en,
    input  logic [1:0]        cfg_page_cyc,
    input  logic [1:0]        cfg_page_size,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs,
    output logic              mem_rd,
    input  logic [31:0]       mem_data
);
    localparam int unsigned CW = (WAIT_W > 3) ? WAIT_W : 3;

    seq_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    pg_cfg_t           cap_cfg;
    logic [CW-1:0]     cap_first;
    logic              rd_valid_q;
    logic [31:0]       rd_data_q;

    logic [CW-1:0]     wait_ext;
    logic [CW-1:0]     min_first;
    logic [CW-1:0]     first_now;
    logic [CW-1:0]     page_len;
    logic              load;
    logic [CW-1:0]     load_val;
    logic              acc_last;
    logic [ADDR_W-1:0] next_addr;
    logic              same_page;
    logic              stay_page;

    // First-access length, clamped to page cycles + 1.
    assign wait_ext  = CW'(cfg_wait);
    assign min_first = CW'(page_cycles(cfg_page_cyc) + 3'd1);
    assign first_now = (wait_ext > min_first) ? wait_ext : min_first;
    assign page_len  = CW'(page_cycles(cap_cfg.cyc_code));

    pgrom_pagechk #(.AW(ADDR_W)) u_page (
        .cur_addr  (cur_addr),
        .size_code (cap_cfg.size_code),
        .next_addr (next_addr),
        .same_page (same_page)
    );

    pgrom_cycle #(.CW(CW)) u_cyc (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .last     (acc_last)
    );

    assign stay_page = cap_cfg.page_on && same_page;

    always_comb begin
        load     = 1'b0;
        load_val = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    load     = 1'b1;
                    load_val = first_now;
                end
            end
            ST_ACC: begin
                if (acc_last && (remain != LEN_W'(1)) && stay_page) begin
                    load     = 1'b1;
                    load_val = page_len;
                end
            end
            ST_GAP: begin
                if (remain != '0) begin
                    load     = 1'b1;
                    load_val = cap_first;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            remain     <= '0;
            cap_cfg    <= '{page_on: 1'b0, cyc_code: 2'b00, size_code: SIZE_CODE_RST};
            cap_first  <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state     <= ST_ACC;
                        cur_addr  <= req_addr & ~ADDR_W'(BUS_BYTES - 1);
                        remain    <= (req_len == '0) ? LEN_W'(1) : req_len;
                        cap_cfg   <= '{page_on:   cfg_page_en & req_page_region,
                                       cyc_code:  cfg_page_cyc,
                                       size_code: cfg_page_size};
                        cap_first <= first_now;
                    end
                end
                ST_ACC: begin
                    if (acc_last) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= mem_data;
                        remain     <= remain - LEN_W'(1);
                        if (remain == LEN_W'(1)) begin
                            state <= ST_GAP;
                        end else begin
                            cur_addr <= next_addr;
                            state    <= stay_page ? ST_ACC : ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    state <= (remain == '0) ? ST_IDLE : ST_ACC;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign mem_cs    = (state == ST_ACC);
    assign mem_rd    = (state == ST_ACC);
    assign mem_addr  = cur_addr;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
endmodule

// File: rtl/pgrom_chk.sv
module pgrom_chk #(
    parameter int unsigned AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          mem_cs,
    input logic [AW-1:0] mem_addr,
    input logic          rd_valid,
    input logic [1:0]    cap_size
);
    logic [2:0] shf;
    assign shf = 3'd6 - {1'b0, cap_size};

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_cs);

    p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_cs |-> (mem_addr[1:0] == 2'b00));

    // R5: an unbroken strobe never spans two pages.
    p_one_page_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && $past(mem_cs)) |-> ((mem_addr >> shf) == ($past(mem_addr) >> shf)));

    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && $past(mem_cs) && (mem_addr != $past(mem_addr)))
            |-> (mem_addr == $past(mem_addr) + AW'(4)));

    p_valid_src_r10: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(mem_cs));

    p_gap_busy_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cs) |-> !req_ready);
endmodule

bind pgrom_seq pgrom_chk #(.AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .mem_cs    (mem_cs),
    .mem_addr  (mem_addr),
    .rd_valid  (rd_valid),
    .cap_size  (cap_cfg.size_code)
);

// File: tb/sim_pgrom_seq.sv
module sim_pgrom_seq;
    localparam int AW = 24;
    localparam int LW = 6;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_page_region = 1'b0;
    logic          req_ready;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          cfg_page_en = 1'b0;
    logic [1:0]    cfg_page_cyc = 2'b00;
    logic [1:0]    cfg_page_size = 2'b10;
    logic [WW-1:0] cfg_wait = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_cs;
    logic          mem_rd;
    logic [31:0]   mem_data;

    always #4 clk = ~clk;

    function automatic logic [31:0] rom_word(input logic [AW-1:0] a);
        return {8'hC3, a} ^ 32'h0F0F_5A5A;
    endfunction

    assign mem_data = rom_word(mem_addr);

    pgrom_seq #(.ADDR_W(AW), .LEN_W(LW), .WAIT_W(WW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_page_region(req_page_region), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .cfg_page_en(cfg_page_en),
        .cfg_page_cyc(cfg_page_cyc), .cfg_page_size(cfg_page_size), .cfg_wait(cfg_wait),
        .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_rd(mem_rd), .mem_data(mem_data)
    );

    typedef struct {
        bit cs;
        bit ready;
        int addr;
        bit valid;
        int data;
    } exp_t;

    exp_t  q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    armed = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Reference comparison on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            exp_t e;
            if (q.size() > 0) e = q.pop_front();
            else e = '{cs: 1'b0, ready: 1'b1, addr: 0, valid: 1'b0, data: 0};
            chk(cur_req, "mem_cs", int'(mem_cs), int'(e.cs));
            chk(cur_req, "mem_rd", int'(mem_rd), int'(e.cs));
            chk(cur_req, "req_ready", int'(req_ready), int'(e.ready));
            chk(cur_req, "rd_valid", int'(rd_valid), int'(e.valid));
            if (e.cs) chk(cur_req, "mem_addr", int'(mem_addr), e.addr);
            if (e.valid) chk(cur_req, "rd_data", int'(rd_data), e.data);
        end
    end

    task automatic burst(input int addr, input int len, input bit region, input bit pen,
                         input int cyc, input int size, input int wt, input bit scramble);
        int  nw, base, pc, nfirst, shift, prev, a, alen;
        bit  paging, pend, inpage;
        int  pdata;
        @(posedge clk); #2;
        req_valid = 1'b1; req_addr = AW'(addr); req_len = LW'(len);
        req_page_region = region; cfg_page_en = pen; cfg_page_cyc = 2'(cyc);
        cfg_page_size = 2'(size); cfg_wait = WW'(wt);
        nw = (len == 0) ? 1 : len;
        base = addr & ~3;
        pc = cyc + 1;
        nfirst = (wt > pc + 1) ? wt : pc + 1;
        shift = 6 - size;
        paging = pen && region;
        pend = 1'b0; pdata = 0; prev = base;
        q.push_back('{cs: 1'b0, ready: 1'b1, addr: 0, valid: 1'b0, data: 0});
        for (int i = 0; i < nw; i++) begin
            a = base + 4 * i;
            inpage = (i > 0) && paging && ((a >> shift) == (prev >> shift));
            if (i > 0 && !inpage) begin
                q.push_back('{cs: 1'b0, ready: 1'b0, addr: 0, valid: pend, data: pdata});
                pend = 1'b0;
            end
            alen = inpage ? pc : nfirst;
            for (int c = 0; c < alen; c++) begin
                q.push_back('{cs: 1'b1, ready: 1'b0, addr: a, valid: pend, data: pdata});
                pend = 1'b0;
            end
            pend = 1'b1; pdata = int'(rom_word(AW'(a))); prev = a;
        end
        q.push_back('{cs: 1'b0, ready: 1'b0, addr: 0, valid: pend, data: pdata});
        @(posedge clk); #2;
        req_valid = 1'b0;
        if (scramble) begin
            cfg_page_en = ~pen; cfg_page_cyc = ~2'(cyc);
            cfg_page_size = ~2'(size); cfg_wait = ~WW'(wt);
            req_page_region = ~region;
        end
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "mem_cs", int'(mem_cs), 0);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        armed = 1'b1;

        cur_req = "R3";   // n=5 first, then 1-cycle page reads in one 16-byte page
        burst(32'h100, 4, 1, 1, 0, 2, 5, 0);
        burst(32'h100, 2, 1, 1, 1, 2, 0, 0);   // wait 0 clamped to 3
        cur_req = "R4";
        burst(32'h140, 4, 1, 1, 3, 0, 2, 0);
        burst(32'h180, 4, 1, 1, 1, 0, 7, 0);
        burst(32'h1C0, 4, 1, 1, 2, 1, 4, 0);
        cur_req = "R5";
        burst(32'h230, 8, 1, 1, 0, 0, 3, 0);   // 64-byte page, crosses 0x240
        burst(32'h218, 4, 1, 1, 0, 1, 3, 0);   // 32-byte page, crosses 0x220
        burst(32'h304, 6, 1, 1, 1, 3, 4, 0);   // 8-byte pages
        cur_req = "R7";
        burst(32'h108, 6, 1, 1, 2, 2, 6, 0);
        cur_req = "R8";
        burst(32'h400, 3, 1, 0, 0, 2, 3, 0);
        burst(32'h400, 3, 0, 1, 0, 2, 3, 0);
        cur_req = "R2";
        burst(32'h10F, 0, 1, 1, 0, 2, 2, 0);
        cur_req = "R9";
        burst(32'h500, 4, 1, 1, 1, 0, 9, 0);
        cur_req = "R10";
        burst(32'h600, 8, 1, 1, 0, 0, 2, 0);
        cur_req = "R11";
        burst(32'h700, 1, 1, 1, 0, 2, 2, 0);
        cur_req = "R12";
        burst(32'h7F4, 6, 1, 1, 0, 2, 3, 1);
        cur_req = "R6";
        seed = 32'h1234_5678;
        for (int k = 0; k < 40; k++) begin
            seed = seed * 1103515245 + 12345;
            burst((seed >>> 4) & 32'h3FFF, ((seed >>> 20) & 15) + 1, seed[1], seed[2] | seed[3],
                  (seed >>> 5) & 3, (seed >>> 7) & 3, (seed >>> 9) & 15, seed[0]);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule